// File: doc/BRIEF.md
# Button Status and Key Control Register Block

This block gives a processor a view of ten push buttons through two read-only byte addresses. It also holds one 16-bit key control register that software can read and write. The button inputs are raw and active-high (1 means pressed). They come from pads that are asynchronous to the bus clock, so they pass through a two-flop synchronizer. A blocking stage then removes physically impossible direction combinations. The result is stored and reported active-low: a 0 bit means pressed and a 1 bit means released.

The direction buttons sit on fixed positions: up on bit 7, down on bit 6, left on bit 5 and right on bit 4. If both members of an opposing pair are seen pressed together, both are reported as released. The other buttons are unaffected. The control register is only storage. Software writes it one byte lane at a time, and the block does not interpret its contents.

Bus accesses are byte wide. A 2-bit address selects one of four byte locations. Reads are registered: data appears one cycle after the read strobe, together with a valid flag.

Top module: `keypad_status`

## Requirements
- R1: After reset, address 0 reads 0xFF, address 1 reads 0x03, and addresses 2 and 3 read 0x00.
- R2: Address 0 bit n reads as the inverse of button n, for buttons 0 to 7, whenever no opposing pair is fully pressed.
- R3: Address 1 bits 1:0 read as the inverse of buttons 9:8, and address 1 bits 7:2 always read 0.
- R4: When up (button 7) and down (button 6) are both pressed, address 0 bits 7 and 6 both read 1.
- R5: When left (button 5) and right (button 4) are both pressed, address 0 bits 5 and 4 both read 1.
- R6: Blocking one pair leaves every other button, including the other pair, reported as usual.
- R7: A write to address 2 replaces control bits 7:0, and a write to address 3 replaces control bits 15:8. The other lane keeps its value, and each lane reads back what was last written to it.
- R8: Writes to addresses 0 and 1 change neither the status nor the control register.
- R9: A change on the raw button inputs is reflected in the stored status on the third rising clock edge after it is applied, and not earlier.
- R10: A read strobe produces rd_valid and rd_data exactly one cycle later, and rd_valid stays 0 when no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keys_raw | input | 10 | Raw button states, active-high, asynchronous |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | Byte address: 0 status low, 1 status high, 2 control low, 3 control high |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, registered |
| rd_valid | output | 1 | High for one cycle when rd_data holds the result of a read |

## Verification
Some properties are checked on every cycle by the assertions. The stored status never shows both members of an opposing pair as pressed. The unused high status bits read as zero. A control lane changes only when a write to its own address occurs, and then to the written byte. A read strobe is always answered one cycle later. Other behaviour can only be shown by the bench's scenarios. These include the exact three-edge input latency, the reset values, the blocking applied to each pair alone and to both pairs together, and the fact that writes to status addresses are ignored.

// File: rtl/keypad_pkg.sv
// Package: shared sizes, button positions and byte address map for the
// button status block. Assumes ten buttons with directions on bits 7..4.
package keypad_pkg;
    localparam int NUM_KEYS    = 10;
    localparam int BYTE_W      = 8;
    localparam int CTRL_W      = 16;
    localparam int SYNC_STAGES = 2;
    localparam int ADDR_W      = 2;

    localparam int KEY_UP    = 7;
    localparam int KEY_DOWN  = 6;
    localparam int KEY_LEFT  = 5;
    localparam int KEY_RIGHT = 4;

    typedef enum logic [ADDR_W-1:0] {
        LOC_STAT_LO = 2'd0,
        LOC_STAT_HI = 2'd1,
        LOC_CTRL_LO = 2'd2,
        LOC_CTRL_HI = 2'd3
    } loc_e;
endpackage

// File: rtl/key_sync.sv
// Module: multi-stage synchronizer for a bus of asynchronous level inputs.
// Assumes inputs are slow levels; no bus coherency is required between bits.
// Reset value of every stage is RST_VAL.
module key_sync #(
    parameter int          WIDTH   = 10,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the sampled value one stage toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_async;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/key_pair_block.sv
// Module: removes impossible opposing-direction combinations and stores the
// result active-low. Assumes active-high pressed inputs that are already
// synchronized. Status resets to "all released" (all ones).
module key_pair_block
    import keypad_pkg::*;
#(
    parameter int WIDTH = NUM_KEYS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pressed,
    output logic [WIDTH-1:0] status_n
);
    logic [WIDTH-1:0] cleaned;
    logic             vert_clash;
    logic             horiz_clash;

    // Detect each opposing pair fully pressed and drop both of its members.
    always_comb begin
        vert_clash  = pressed[KEY_UP]   & pressed[KEY_DOWN];
        horiz_clash = pressed[KEY_LEFT] & pressed[KEY_RIGHT];
        cleaned     = pressed;
        if (vert_clash) begin
            cleaned[KEY_UP]   = 1'b0;
            cleaned[KEY_DOWN] = 1'b0;
        end
        if (horiz_clash) begin
            cleaned[KEY_LEFT]  = 1'b0;
            cleaned[KEY_RIGHT] = 1'b0;
        end
    end

    // Store the cleaned pattern inverted, so that a 0 bit means pressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_n <= '1;
        end else begin
            status_n <= ~cleaned;
        end
    end

    // R4: stored status never shows up and down pressed together.
    p_no_vert_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!status_n[KEY_UP] && !status_n[KEY_DOWN]));

    // R5: stored status never shows left and right pressed together.
    p_no_horiz_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!status_n[KEY_LEFT] && !status_n[KEY_RIGHT]));

    // R6: a pressed input with its opposite released is reported pressed.
    p_single_up_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pressed[KEY_UP] && !pressed[KEY_DOWN]) |=> !status_n[KEY_UP]);
endmodule

// File: rtl/key_ctrl_reg.sv
// Module: control register written one byte lane at a time. The contents
// are not interpreted here. Assumes at most one lane is written per cycle.
// Resets to zero.
module key_ctrl_reg
    import keypad_pkg::*;
#(
    parameter int LANES = CTRL_W / BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_we,
    input  logic [BYTE_W-1:0]       wdata,
    output logic [LANES*BYTE_W-1:0] value
);
    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Update one byte lane when its write enable is set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    value[l*BYTE_W +: BYTE_W] <= '0;
                end else if (lane_we[l]) begin
                    value[l*BYTE_W +: BYTE_W] <= wdata;
                end
            end

            // R7: a lane takes the written byte.
            p_lane_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
                lane_we[l] |=> value[l*BYTE_W +: BYTE_W] == $past(wdata));

            // R7: a lane without a write keeps its value.
            p_lane_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !lane_we[l] |=> $stable(value[l*BYTE_W +: BYTE_W]));
        end
    endgenerate
endmodule

// File: rtl/keypad_status.sv
// Module: top of the button status block. Synchronizes raw buttons, blocks
// opposing pairs, stores the status active-low and serves four byte
// locations with registered reads. Assumes a byte-wide single-master bus.
module keypad_status
    import keypad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_KEYS-1:0] keys_raw,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int LANES  = CTRL_W / BYTE_W;
    localparam int HI_KEYS = NUM_KEYS - BYTE_W;

    logic [NUM_KEYS-1:0]     keys_sync;
    logic [NUM_KEYS-1:0]     status_n;
    logic [CTRL_W-1:0]       ctrl_val;
    logic [LANES-1:0]        lane_we;
    logic [BYTE_W-1:0]       rd_next;
    loc_e                    loc;

    assign loc = loc_e'(addr);

    key_sync #(
        .WIDTH  (NUM_KEYS),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(keys_raw),
        .q_sync (keys_sync)
    );

    key_pair_block #(
        .WIDTH(NUM_KEYS)
    ) i_block (
        .clk     (clk),
        .rst_n   (rst_n),
        .pressed (keys_sync),
        .status_n(status_n)
    );

    // Decode byte-lane write enables; status locations take no writes.
    always_comb begin
        lane_we    = '0;
        lane_we[0] = wr_en && (loc == LOC_CTRL_LO);
        lane_we[1] = wr_en && (loc == LOC_CTRL_HI);
    end

    key_ctrl_reg #(
        .LANES(LANES)
    ) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_we(lane_we),
        .wdata  (wr_data),
        .value  (ctrl_val)
    );

    // Select the byte to return for the addressed location.
    always_comb begin
        rd_next = '0;
        unique case (loc)
            LOC_STAT_LO: rd_next = status_n[BYTE_W-1:0];
            LOC_STAT_HI: rd_next[HI_KEYS-1:0] = status_n[NUM_KEYS-1:BYTE_W];
            LOC_CTRL_LO: rd_next = ctrl_val[BYTE_W-1:0];
            LOC_CTRL_HI: rd_next = ctrl_val[CTRL_W-1:BYTE_W];
            default:     rd_next = '0;
        endcase
    end

    // Register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= rd_next;
            end
        end
    end

    // R10: each read strobe is answered exactly one cycle later.
    p_read_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R10: no valid flag without a preceding strobe.
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R3: upper bits of the high status byte read as zero.
    p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && loc == LOC_STAT_HI) |=> rd_data[BYTE_W-1:HI_KEYS] == '0);

    // R8: status writes leave the control register unchanged.
    p_stat_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (loc == LOC_STAT_LO || loc == LOC_STAT_HI)) |=> $stable(ctrl_val));
endmodule

// File: tb/test_keypad_status.sv
// Scoreboard bench: driver tasks push expected read bytes, a monitor pops
// and compares them whenever rd_valid is seen.
module test_keypad_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] keys_raw = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0;
    int failures = 0;
    logic [7:0]  exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    keypad_status i_keypad_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .keys_raw(keys_raw),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    // Expected low status byte from the requirements (R2, R4, R5, R6).
    function automatic logic [7:0] exp_lo(input logic [9:0] k);
        logic [7:0] m = k[7:0];
        if (m[7] && m[6]) begin m[7] = 1'b0; m[6] = 1'b0; end
        if (m[5] && m[4]) begin m[5] = 1'b0; m[4] = 1'b0; end
        return m ^ 8'hFF;
    endfunction

    // Expected high status byte (R3).
    function automatic logic [7:0] exp_hi(input logic [9:0] k);
        return {6'b0, k[9:8] ^ 2'b11};
    endfunction

    // Issue one read at the current negedge and queue its expected byte.
    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        rd_en = 1'b1;
        addr  = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Apply a button pattern, let it settle, and check both status bytes.
    task automatic keys_check(input logic [9:0] k, input string tag);
        keys_raw = k;
        repeat (3) @(negedge clk);
        rd(2'd0, exp_lo(k), tag);
        rd(2'd1, exp_hi(k), tag);
    endtask

    // Monitor: compare each returned byte with the queue head.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R10: unexpected read data %h, expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    failures++;
                    $display("FAIL %s: actual %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(2'd0, 8'hFF, "R1");
        rd(2'd1, 8'h03, "R1");
        rd(2'd2, 8'h00, "R1");
        rd(2'd3, 8'h00, "R1");
        // R2 / R3 plain patterns
        keys_check(10'b00_0000_0001, "R2");
        keys_check(10'b00_1010_0101, "R2");
        keys_check(10'b01_0000_0000, "R3");
        keys_check(10'b11_0000_1111, "R3");
        // R4 up+down, R5 left+right, R6 other buttons survive
        keys_check(10'b00_1100_0000, "R4");
        keys_check(10'b10_1100_0011, "R4");
        keys_check(10'b00_0011_0000, "R5");
        keys_check(10'b01_0011_1100, "R5");
        keys_check(10'b00_1101_0000, "R6");
        keys_check(10'b00_0111_0000, "R6");
        keys_check(10'b11_1111_1111, "R6");
        keys_check(10'b00_1000_0000, "R6");
        // R9 latency: old value after two edges, new value after three
        keys_raw = 10'b00_0000_0000;
        repeat (3) @(negedge clk);
        keys_raw = 10'b00_0000_0010;
        @(negedge clk);
        @(negedge clk);
        rd(2'd0, 8'hFF, "R9");
        rd(2'd0, 8'hFD, "R9");
        // R7 byte lane writes
        wr(2'd2, 8'hA5);
        rd(2'd2, 8'hA5, "R7");
        rd(2'd3, 8'h00, "R7");
        wr(2'd3, 8'h3C);
        rd(2'd2, 8'hA5, "R7");
        rd(2'd3, 8'h3C, "R7");
        wr(2'd2, 8'h0F);
        rd(2'd2, 8'h0F, "R7");
        rd(2'd3, 8'h3C, "R7");
        // R8 writes to status locations ignored
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd0, 8'hFD, "R8");
        rd(2'd1, 8'h03, "R8");
        rd(2'd2, 8'h0F, "R8");
        rd(2'd3, 8'h3C, "R8");
        // R10 no spurious valid while idle, then queue drained
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R10: actual %0d pending expected 0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule